// File: doc/BRIEF.md
# Burst Field Serial Receiver

This block sits behind the synchronisation logic of a radio burst receiver. Once sync is found, a serial bit stream arrives with a one-cycle enable per recovered data-clock period. The block packs the control field (16 nibbles) and then the payload field (80 nibbles) into 4-bit nibbles. It hands each nibble, with its target address, to a shared data memory over a valid/ready write stream.

The host loads two start addresses through a small register port before each burst. The control-field start is copied into a working pointer when a burst starts. The payload-field start goes into a shadow register. That shadow is copied into the payload pointer only at the last control-field nibble, so the host may rewrite it while the control field is still arriving.

During the control field the block runs a CRC-16 check and reports the result. It also decodes a 3-bit header tag to flag a ciphered burst. All other bits are stored as they arrive, without interpretation.

The write stream follows valid/ready rules. `mem_valid` stays high, with address and data held, until `mem_ready` is seen high on a clock edge. The receiver cannot stall the radio. If a new nibble completes while the previous one is still waiting, the new nibble is dropped and a sticky overrun flag is set. The memory side must therefore accept each write within four bit periods.

Top module: `burst_rx`

## Requirements
- R1: After reset, `mem_valid`, `busy`, `a_done`, `a_crc_ok`, `cipher_flag`, `overrun` and `burst_done` are all 0.
- R2: Bits are packed MSB-first. The first bit of each group of four received bits becomes data bit 3 of the nibble.
- R3: Control-field nibble k (k = 0..15) is written to address A+k. A is the value last written with `cfg_sel`=0 before `start`.
- R4: Payload nibble k (k = 0..79) is written to address B+k. B is the value held with `cfg_sel`=1 when the last control-field bit is taken. A write made during the control field takes effect for that burst. A write made during the payload field does not change the current burst.
- R5: While `mem_valid` is high and `mem_ready` is low, `mem_valid`, `mem_addr` and `mem_data` hold their values.
- R6: If a nibble completes while a write is still pending, that nibble is dropped and `overrun` goes to 1. `overrun` stays at 1 until the next accepted `start`.
- R7: After the 64th bit, `a_done` pulses for one cycle. At that point `a_crc_ok` shows whether the CRC-16 of the 64 control bits is 0. The CRC uses polynomial 0x0589, MSB-first, with an initial value of 0.
- R8: Received bits are indexed from 0. After bit 3, `cipher_flag` is 1 exactly when bits 1,2,3 (bit 1 as the MSB) equal 3'b110. `start` clears the flag.
- R9: `bit_in` is ignored in any cycle where `bit_en` is low.
- R10: After bit 383, `burst_done` pulses for one cycle and `busy` returns to 0.
- R11: While idle, bits that arrive produce no memory writes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Pulse: burst begins (accepted only when idle) |
| bit_en | input | 1 | One-cycle strobe per recovered bit |
| bit_in | input | 1 | Serial data, sampled when `bit_en` is high |
| cfg_we | input | 1 | Host register write strobe |
| cfg_sel | input | 1 | 0: control-field start, 1: payload-field start |
| cfg_data | input | ADDR_W | Start address to load |
| mem_valid | output | 1 | Write request valid |
| mem_ready | input | 1 | Memory accepts the write |
| mem_addr | output | ADDR_W | Write address |
| mem_data | output | 4 | Nibble to write |
| busy | output | 1 | Burst reception in progress |
| a_done | output | 1 | Pulse at the end of the control field |
| a_crc_ok | output | 1 | Control-field CRC result |
| cipher_flag | output | 1 | Ciphered burst detected from the header |
| overrun | output | 1 | A nibble was dropped under back-pressure |
| burst_done | output | 1 | Pulse after the last payload bit |

## Verification
Several bursts are generated from different pseudo-random seeds, start addresses and header tags. Some carry a valid CRC and one has a flipped bit. These separate correct field addressing and nibble order from the CRC and cipher decisions. Each burst rewrites the payload start with a decoy before `start`, the real value during the control field, and a second decoy during the payload. This tells double-buffered loading apart from loading at the wrong time. Runs with `mem_ready` asserted one cycle in three, and with a long stall, separate correct holding from dropping with overrun. Garbage toggled on `bit_in` between strobes, while idle, and right after `start` shows that unstrobed bits are ignored.

// File: rtl/burst_rx_pkg.sv
`timescale 1ns/1ps
package burst_rx_pkg;
  typedef enum logic [1:0] {RX_IDLE, RX_AFLD, RX_BFLD} rx_state_t;
  localparam int unsigned NIB_W = 4;
  localparam int unsigned POS_W = $clog2(NIB_W);
  localparam logic SEL_A = 1'b0;
  localparam logic SEL_B = 1'b1;
endpackage

// File: rtl/burst_rx_pack.sv
`timescale 1ns/1ps
module burst_rx_pack
  import burst_rx_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             take,
  input  logic             din,
  output logic             nib_done,
  output logic [NIB_W-1:0] nib_val
);
  logic [POS_W-1:0] pos;
  logic [NIB_W-2:0] sh;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pos <= '0;
      sh  <= '0;
    end else if (clr) begin
      pos <= '0;
    end else if (take) begin
      pos <= pos + 1'b1;
      sh  <= {sh[NIB_W-3:0], din};
    end
  end

  // earliest bit ends up in the MSB
  assign nib_done = take && (pos == POS_W'(NIB_W-1));
  assign nib_val  = {sh, din};
endmodule

// File: rtl/burst_rx_crc.sv
`timescale 1ns/1ps
module burst_rx_crc #(
  parameter int unsigned  CRC_W = 16,
  parameter logic [CRC_W-1:0] POLY = 16'h0589
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             en,
  input  logic             din,
  output logic [CRC_W-1:0] crc_nxt
);
  logic [CRC_W-1:0] crc_q;
  logic             fb;

  always_comb begin
    fb      = crc_q[CRC_W-1] ^ din;
    crc_nxt = {crc_q[CRC_W-2:0], 1'b0} ^ (fb ? POLY : '0);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   crc_q <= '0;
    else if (clr) crc_q <= '0;
    else if (en)  crc_q <= crc_nxt;
  end
endmodule

// File: rtl/burst_rx_addr.sv
`timescale 1ns/1ps
module burst_rx_addr
  import burst_rx_pkg::*;
#(
  parameter int unsigned ADDR_W = 9
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic              cfg_sel,
  input  logic [ADDR_W-1:0] cfg_data,
  input  logic              load_a,
  input  logic              load_b,
  input  logic              inc_a,
  input  logic              inc_b,
  output logic [ADDR_W-1:0] a_ptr,
  output logic [ADDR_W-1:0] b_ptr
);
  logic [ADDR_W-1:0] a_cfg, b_shadow;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      a_cfg    <= '0;
      b_shadow <= '0;
    end else if (cfg_we) begin
      if (cfg_sel == SEL_A) a_cfg    <= cfg_data;
      else                  b_shadow <= cfg_data;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      a_ptr <= '0;
    else if (load_a) a_ptr <= a_cfg;
    else if (inc_a)  a_ptr <= a_ptr + 1'b1;
  end

  // payload pointer takes the shadow only at the field boundary
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      b_ptr <= '0;
    else if (load_b) b_ptr <= b_shadow;
    else if (inc_b)  b_ptr <= b_ptr + 1'b1;
  end
endmodule

// File: rtl/burst_rx.sv
`timescale 1ns/1ps
module burst_rx
  import burst_rx_pkg::*;
#(
  parameter int unsigned      ADDR_W      = 9,
  parameter int unsigned      A_NIBS      = 16,
  parameter int unsigned      B_NIBS      = 80,
  parameter int unsigned      CRC_W       = 16,
  parameter logic [CRC_W-1:0] CRC_POLY    = 16'h0589,
  parameter logic [CRC_W-1:0] CRC_RESIDUE = '0,
  parameter logic [2:0]       CIPHER_TAG  = 3'b110
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              bit_en,
  input  logic              bit_in,
  input  logic              cfg_we,
  input  logic              cfg_sel,
  input  logic [ADDR_W-1:0] cfg_data,
  output logic              mem_valid,
  input  logic              mem_ready,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [3:0]        mem_data,
  output logic              busy,
  output logic              a_done,
  output logic              a_crc_ok,
  output logic              cipher_flag,
  output logic              overrun,
  output logic              burst_done
);
  localparam int unsigned A_BITS   = A_NIBS * NIB_W;
  localparam int unsigned TOT_BITS = (A_NIBS + B_NIBS) * NIB_W;
  localparam int unsigned CNT_W    = $clog2(TOT_BITS);

  rx_state_t         state;
  logic [CNT_W-1:0]  bit_idx;
  logic              take, in_a, last_a, last_all, go;
  logic              nib_done;
  logic [NIB_W-1:0]  nib_val;
  logic [CRC_W-1:0]  crc_nxt;
  logic [ADDR_W-1:0] a_ptr, b_ptr;
  logic [1:0]        hdr;

  assign go       = start && (state == RX_IDLE);
  assign take     = bit_en && (state != RX_IDLE);
  assign in_a     = (state == RX_AFLD);
  assign last_a   = take && in_a && (bit_idx == CNT_W'(A_BITS-1));
  assign last_all = take && (bit_idx == CNT_W'(TOT_BITS-1));
  assign busy     = (state != RX_IDLE);

  burst_rx_pack pack_i (
    .clk(clk), .rst_n(rst_n), .clr(go), .take(take), .din(bit_in),
    .nib_done(nib_done), .nib_val(nib_val)
  );

  burst_rx_crc #(.CRC_W(CRC_W), .POLY(CRC_POLY)) crc_i (
    .clk(clk), .rst_n(rst_n), .clr(go), .en(take && in_a), .din(bit_in),
    .crc_nxt(crc_nxt)
  );

  burst_rx_addr #(.ADDR_W(ADDR_W)) addr_i (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
    .cfg_data(cfg_data), .load_a(go), .load_b(last_a),
    .inc_a(nib_done && in_a), .inc_b(nib_done && (state == RX_BFLD)),
    .a_ptr(a_ptr), .b_ptr(b_ptr)
  );

  // sequencing through the two fields
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state      <= RX_IDLE;
      bit_idx    <= '0;
      burst_done <= 1'b0;
    end else begin
      burst_done <= 1'b0;
      if (go) begin
        state   <= RX_AFLD;
        bit_idx <= '0;
      end else if (take) begin
        bit_idx <= bit_idx + 1'b1;
        if (last_a) state <= RX_BFLD;
        if (last_all) begin
          state      <= RX_IDLE;
          burst_done <= 1'b1;
        end
      end
    end
  end

  // header tag and CRC verdict
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hdr         <= '0;
      cipher_flag <= 1'b0;
      a_crc_ok    <= 1'b0;
      a_done      <= 1'b0;
    end else begin
      a_done <= 1'b0;
      if (go) begin
        cipher_flag <= 1'b0;
        a_crc_ok    <= 1'b0;
      end else if (take && in_a) begin
        if (bit_idx == CNT_W'(1) || bit_idx == CNT_W'(2)) hdr <= {hdr[0], bit_in};
        if (bit_idx == CNT_W'(3)) cipher_flag <= ({hdr, bit_in} == CIPHER_TAG);
        if (last_a) begin
          a_done   <= 1'b1;
          a_crc_ok <= (crc_nxt == CRC_RESIDUE);
        end
      end
    end
  end

  // write stream with one pending slot
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mem_valid <= 1'b0;
      mem_addr  <= '0;
      mem_data  <= '0;
      overrun   <= 1'b0;
    end else begin
      if (go) overrun <= 1'b0;
      if (mem_valid && mem_ready) mem_valid <= 1'b0;
      if (nib_done) begin
        if (mem_valid && !mem_ready) begin
          overrun <= 1'b1;
        end else begin
          mem_valid <= 1'b1;
          mem_data  <= nib_val;
          mem_addr  <= in_a ? a_ptr : b_ptr;
        end
      end
    end
  end
endmodule

// File: rtl/burst_rx_chk.sv
`timescale 1ns/1ps
module burst_rx_chk #(
  parameter int unsigned ADDR_W = 9
) (
  input logic              clk,
  input logic              rst_n,
  input logic              mem_valid,
  input logic              mem_ready,
  input logic [ADDR_W-1:0] mem_addr,
  input logic [3:0]        mem_data,
  input logic              busy,
  input logic              a_done,
  input logic              cipher_flag,
  input logic              overrun,
  input logic              burst_done
);
  assert_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_valid && !mem_ready) |=> (mem_valid && $stable(mem_addr) && $stable(mem_data)));

  assert_idle_quiet_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |=> !$rose(mem_valid));

  assert_overrun_cause_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(overrun) |-> $past(mem_valid && !mem_ready));

  assert_adone_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
    a_done |=> !a_done);

  assert_cipher_busy_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cipher_flag) |-> busy);

  assert_done_end_R10: assert property (@(posedge clk) disable iff (!rst_n)
    burst_done |-> (!busy && $past(busy)));

  assert_done_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
    burst_done |=> !burst_done);
endmodule

bind burst_rx burst_rx_chk #(.ADDR_W(ADDR_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .mem_valid(mem_valid), .mem_ready(mem_ready),
  .mem_addr(mem_addr), .mem_data(mem_data), .busy(busy), .a_done(a_done),
  .cipher_flag(cipher_flag), .overrun(overrun), .burst_done(burst_done)
);

// File: tb/burst_rx_tb_top.sv
`timescale 1ns/1ps
module burst_rx_tb_top;
  localparam int AW = 9;
  localparam int NBITS = 384;
  localparam logic [15:0] POLY = 16'h0589;

  // {a_start, b_start, seed, tag, corrupt}
  localparam logic [37:0] VEC [4] = '{
    {9'd0,   9'd16,  16'h0001, 3'b110, 1'b0},
    {9'd100, 9'd200, 16'hACE1, 3'b011, 1'b0},
    {9'd300, 9'd400, 16'h1234, 3'b110, 1'b1},
    {9'd496, 9'd0,   16'hBEEF, 3'b000, 1'b0}
  };

  logic clk = 0, rst_n = 0;
  logic start = 0, bit_en = 0, bit_in = 0, cfg_we = 0, cfg_sel = 0;
  logic [AW-1:0] cfg_data = '0;
  logic mem_valid, mem_ready, busy, a_done, a_crc_ok, cipher_flag, overrun, burst_done;
  logic [AW-1:0] mem_addr;
  logic [3:0] mem_data;

  always #10 clk = ~clk;

  burst_rx dut_i (
    .clk(clk), .rst_n(rst_n), .start(start), .bit_en(bit_en), .bit_in(bit_in),
    .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_data(cfg_data),
    .mem_valid(mem_valid), .mem_ready(mem_ready), .mem_addr(mem_addr),
    .mem_data(mem_data), .busy(busy), .a_done(a_done), .a_crc_ok(a_crc_ok),
    .cipher_flag(cipher_flag), .overrun(overrun), .burst_done(burst_done)
  );

  int nchk = 0, nfail = 0, wcount = 0, adone_cnt = 0, done_cnt = 0, cyc = 0;
  int rdy_mode = 0;
  logic stall = 0, finished = 0;
  logic [3:0] model [0:(1<<AW)-1];
  logic       bits  [0:NBITS-1];

  always @(negedge clk) begin
    cyc <= cyc + 1;
    case (rdy_mode)
      1:       mem_ready <= (cyc % 3 == 0);
      2:       mem_ready <= !stall;
      default: mem_ready <= 1'b1;
    endcase
  end

  always @(posedge clk) begin
    if (mem_valid && mem_ready) begin
      model[mem_addr] <= mem_data;
      wcount <= wcount + 1;
    end
    if (a_done) adone_cnt <= adone_cnt + 1;
    if (burst_done) done_cnt <= done_cnt + 1;
  end

  task automatic check(input string req, input int got, input int exp);
    nchk++;
    if (got != exp) begin
      nfail++;
      $display("FAIL %s: got %0d expected %0d", req, got, exp);
    end
  endtask

  task automatic cfg_write(input logic sel, input logic [AW-1:0] d);
    @(negedge clk); cfg_we = 1; cfg_sel = sel; cfg_data = d;
    @(negedge clk); cfg_we = 0;
  endtask

  task automatic send_bit(input logic b);
    @(negedge clk); bit_en = 1; bit_in = b;
    @(negedge clk); bit_en = 0; bit_in = ~b;
    @(negedge clk); bit_in = b;
    @(negedge clk); bit_in = ~b;
  endtask

  task automatic build_bits(input logic [15:0] seed, input logic [2:0] tag, input logic corr);
    logic [15:0] l = seed;
    logic [15:0] c = '0;
    for (int i = 0; i < NBITS; i++) begin
      bits[i] = l[0];
      l = (l >> 1) ^ (l[0] ? 16'hB400 : 16'h0000);
    end
    bits[1] = tag[2]; bits[2] = tag[1]; bits[3] = tag[0];
    for (int i = 0; i < 48; i++) begin
      logic fb = c[15] ^ bits[i];
      c = {c[14:0], 1'b0} ^ (fb ? POLY : 16'h0000);
    end
    for (int i = 0; i < 16; i++) bits[48+i] = c[15-i];
    if (corr) bits[50] = ~bits[50];
  endtask

  task automatic run_burst(input int vi, input int mode, input int gap);
    logic [37:0] v = VEC[vi];
    logic [AW-1:0] a = v[37:29], b = v[28:20];
    int bad = 0;
    build_bits(v[19:4], v[3:1], v[0]);
    for (int i = 0; i < (1<<AW); i++) model[i] = 4'hx;
    rdy_mode = mode;
    cfg_write(1'b0, a);
    cfg_write(1'b1, a + 9'd7);          // decoy before start
    @(negedge clk); wcount = 0; adone_cnt = 0; done_cnt = 0; start = 1;
    @(negedge clk); start = 0;
    check("R6 overrun cleared by start", overrun, 0);
    if (gap > 0) begin
      repeat (gap) begin @(negedge clk); bit_in = ~bit_in; end
      check("R9 unstrobed bits ignored", wcount, 0);
    end
    for (int i = 0; i < NBITS; i++) begin
      if (i == 10)  cfg_write(1'b1, b);          // real value during control field
      if (i == 200) cfg_write(1'b1, b + 9'd40);  // decoy during payload
      stall = (mode == 2) && (i >= 8) && (i < 40);
      send_bit(bits[i]);
      if (i == 3) check("R8 cipher flag after header", cipher_flag, (v[3:1] == 3'b110));
    end
    stall = 0;
    repeat (6) @(negedge clk);
    if (mode != 2) begin
      for (int k = 0; k < 16; k++)
        if (model[a + AW'(k)] !== {bits[4*k], bits[4*k+1], bits[4*k+2], bits[4*k+3]}) bad++;
      check("R2 R3 control-field nibbles", bad, 0);
      bad = 0;
      for (int k = 0; k < 80; k++)
        if (model[b + AW'(k)] !== {bits[64+4*k], bits[65+4*k], bits[66+4*k], bits[67+4*k]}) bad++;
      check("R4 payload nibbles at double-buffered start", bad, 0);
      check("R3 R4 write count", wcount, 96);
      check("R6 no overrun", overrun, 0);
    end else begin
      check("R6 overrun under stall", overrun, 1);
      check("R6 nibbles dropped", (wcount < 96), 1);
    end
    check("R7 crc verdict", a_crc_ok, !v[0]);
    check("R7 a_done pulses", adone_cnt, 1);
    check("R10 burst_done pulses", done_cnt, 1);
    check("R10 busy low at end", busy, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R1 mem_valid reset", mem_valid, 0);
    check("R1 status reset", {busy, a_done, a_crc_ok, cipher_flag, overrun, burst_done}, 0);
    rst_n = 1;
    repeat (2) @(negedge clk);
    wcount = 0;
    for (int i = 0; i < 20; i++) send_bit(i[0]);
    check("R11 idle bits write nothing", wcount, 0);
    check("R11 still idle", busy, 0);
    for (int vi = 0; vi < 4; vi++) run_burst(vi, 0, 0);
    run_burst(1, 1, 0);   // R5: slow ready
    run_burst(0, 0, 40);  // R9: garbage after start
    run_burst(2, 2, 0);   // R6: long stall
    run_burst(3, 0, 0);   // R6: overrun cleared again
    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end

  initial begin
    #(200000 * 20);
    if (!finished) begin
      nchk++; nfail++;
      $display("FAIL watchdog: got 0 expected 1");
      $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
      $finish;
    end
  end
endmodule